// File: doc/BRIEF.md
# Flash Program Host Sequencer

This block is the host-side controller that carries out one multi-byte program operation on a flash memory that accepts two or four bytes per program command. A client hands it a request through a valid/ready handshake. The request carries a start address, a 32-bit data word, a flag that selects four bytes instead of two, and a flag that selects the alternate program opcode. The sequencer then runs the whole exchange on a simple request/acknowledge bus. It writes the program opcode, writes each data byte, and reads the device status until the device reports ready.

Once the device is ready, the sequencer ranks the error flags in the status byte and returns a two-bit result code. When the code is nonzero, it first writes the clear-status opcode so that the device is clean before the next operation. While the device is busy, a client may ask for a suspend. The sequencer then writes the suspend opcode and parks until it is told to resume. A limit on consecutive busy polls ends an operation that never completes, and that case is reported as a timeout.

Top module: `fps_seq`

## Requirements
- R1: After reset, req_ready is 1, while rsp_valid, bus_req and suspended are all 0.
- R2: The first bus cycle of an operation writes the program opcode to the start address. The opcode is 0x40, or 0x10 when req_alt is 1.
- R3: The opcode write is followed by 2 data writes (req_quad=0) or 4 data writes (req_quad=1). The bytes are taken from req_data least significant byte first, and each one is written to the start address with all of its low bits unchanged.
- R4: After the data writes, the sequencer issues status reads (bus_we=0) at the start address. It keeps reading while bit 7 of the returned byte is 0, and it ignores the error bits while bit 7 is 0.
- R5: When bit 7 is 1, the result code is 1 if bit 3 is set. Otherwise it is 2 if bit 4 is set, 3 if bit 1 is set, and 0 if none of these is set. Other status bits do not affect the code.
- R6: When the result code is nonzero, a write of 0x50 to the start address precedes rsp_valid. When the code is 0, no such write occurs.
- R7: req_ready is 0 from the cycle after a request is accepted until the response handshake completes. A request presented during that time causes no bus cycle.
- R8: A suspend_req pulse during the opcode, data or poll phase takes effect at the next busy status read. The sequencer writes 0xB0 to the start address, then holds suspended=1 with no bus activity until resume_req. It then writes 0xD0 and resumes polling.
- R9: If MAX_POLLS consecutive status reads return bit 7 = 0, the response carries rsp_timeout=1 and rsp_code=0, and no clear-status write is made.
- R10: rsp_valid, rsp_code and rsp_timeout stay stable while rsp_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and accepting a request |
| req_addr | input | ADDR_W | Start address of the program operation |
| req_data | input | 32 | Data bytes, least significant byte programmed first |
| req_quad | input | 1 | 1 selects four bytes, 0 selects two |
| req_alt | input | 1 | 1 selects the alternate program opcode |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Client takes the result |
| rsp_code | output | 2 | 0 ok, 1 voltage, 2 program, 3 protected |
| rsp_timeout | output | 1 | Busy poll limit was reached |
| suspend_req | input | 1 | Pulse requesting suspension of the program operation |
| resume_req | input | 1 | Pulse ending the suspension |
| suspended | output | 1 | Parked in the suspended state |
| bus_req | output | 1 | Bus cycle requested |
| bus_we | output | 1 | 1 write, 0 status read |
| bus_addr | output | ADDR_W | Bus cycle address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Completes the current bus cycle at this edge |

## Verification
The assertions assume that the bus target raises bus_ack only while bus_req is high. They also assume that bus_rdata is valid in any cycle that acknowledges a read, and that resume_req is pulsed only while suspended. The bench's bus model raises bus_ack for exactly one cycle after it sees a request without an acknowledge. It computes the read data at that moment from a per-test count of busy reads. The bench pulses resume_req only after it has observed suspended high.

// File: rtl/fps_pkg.sv
package fps_pkg;
   localparam int BYTE_W   = 8;
   localparam int MAX_BYTES = 4;

   typedef enum logic [3:0] {
      S_IDLE, S_CMD, S_DATA, S_POLL, S_SUSP, S_PARK, S_RESUME, S_CLEAR, S_RESP
   } seq_state_t;

   typedef enum logic [1:0] {
      RC_OK    = 2'd0,
      RC_VOLT  = 2'd1,
      RC_PROG  = 2'd2,
      RC_PROT  = 2'd3
   } result_t;
endpackage

// File: rtl/fps_err_rank.sv
module fps_err_rank
   import fps_pkg::*;
#(
   parameter int VOLT_BIT = 3,
   parameter int PROG_BIT = 4,
   parameter int PROT_BIT = 1
) (
   input  logic [BYTE_W-1:0] stat,
   output result_t           code
);
   if (VOLT_BIT >= BYTE_W || PROG_BIT >= BYTE_W || PROT_BIT >= BYTE_W) begin : g_bad_bit
      $error("fps_err_rank: status bit index out of range");
   end

   always_comb begin
      if (stat[VOLT_BIT])      code = RC_VOLT;
      else if (stat[PROG_BIT]) code = RC_PROG;
      else if (stat[PROT_BIT]) code = RC_PROT;
      else                     code = RC_OK;
   end

   always_comb begin
      a_rank_r5: assert ((code != RC_OK) || (stat[VOLT_BIT] == 1'b0 && stat[PROG_BIT] == 1'b0 && stat[PROT_BIT] == 1'b0));
   end
endmodule

// File: rtl/fps_poll_timer.sv
module fps_poll_timer #(
   parameter int MAX_POLLS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic step,
   output logic last
);
   localparam int CW = (MAX_POLLS > 2) ? $clog2(MAX_POLLS) : 1;

   if (MAX_POLLS < 2) begin : g_bad_limit
      $error("fps_poll_timer: MAX_POLLS must be at least 2");
   end

   logic [CW-1:0] cnt;

   assign last = (cnt == CW'(MAX_POLLS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt <= '0;
      else if (clr)             cnt <= '0;
      else if (step && !last)   cnt <= cnt + 1'b1;
   end

   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      32'(cnt) <= MAX_POLLS - 1);
   p_step_moves_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr && !last) |=> (cnt != $past(cnt)));
endmodule

// File: rtl/fps_seq.sv
module fps_seq
   import fps_pkg::*;
#(
   parameter int          ADDR_W     = 24,
   parameter int          MAX_POLLS  = 16,
   parameter logic [7:0]  OP_PROG    = 8'h40,
   parameter logic [7:0]  OP_PROG_ALT = 8'h10,
   parameter logic [7:0]  OP_CLEAR   = 8'h50,
   parameter logic [7:0]  OP_SUSP    = 8'hB0,
   parameter logic [7:0]  OP_RESUME  = 8'hD0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   output logic                        req_ready,
   input  logic [ADDR_W-1:0]           req_addr,
   input  logic [MAX_BYTES*BYTE_W-1:0] req_data,
   input  logic                        req_quad,
   input  logic                        req_alt,
   output logic                        rsp_valid,
   input  logic                        rsp_ready,
   output logic [1:0]                  rsp_code,
   output logic                        rsp_timeout,
   input  logic                        suspend_req,
   input  logic                        resume_req,
   output logic                        suspended,
   output logic                        bus_req,
   output logic                        bus_we,
   output logic [ADDR_W-1:0]           bus_addr,
   output logic [BYTE_W-1:0]           bus_wdata,
   input  logic [BYTE_W-1:0]           bus_rdata,
   input  logic                        bus_ack
);
   localparam int DATA_W = MAX_BYTES * BYTE_W;
   localparam int IDX_W  = $clog2(MAX_BYTES);
   localparam int RDY_BIT = BYTE_W - 1;

   if (ADDR_W < 2) begin : g_bad_addr
      $error("fps_seq: ADDR_W must cover the byte-lane bits");
   end

   seq_state_t            st;
   logic [ADDR_W-1:0]     addr_q;
   logic [DATA_W-1:0]     data_q;
   logic                  quad_q, alt_q, susp_pend;
   logic [IDX_W-1:0]      idx;
   result_t               code_q, code_w;
   logic                  tmo_q;
   logic                  fire, dev_ready, last_byte, tmr_last, tmr_clr, tmr_step;
   logic [BYTE_W-1:0]     lane [MAX_BYTES];

   for (genvar g = 0; g < MAX_BYTES; g++) begin : g_lane
      assign lane[g] = data_q[g*BYTE_W +: BYTE_W];
   end

   assign fire      = bus_req && bus_ack;
   assign dev_ready = bus_rdata[RDY_BIT];
   assign last_byte = (idx == (quad_q ? IDX_W'(MAX_BYTES - 1) : IDX_W'(1)));
   assign tmr_clr   = fire && ((st == S_DATA && last_byte) || st == S_RESUME);
   assign tmr_step  = fire && st == S_POLL && !dev_ready;

   fps_err_rank u_rank (
      .stat (bus_rdata),
      .code (code_w)
   );

   fps_poll_timer #(.MAX_POLLS(MAX_POLLS)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tmr_clr),
      .step  (tmr_step),
      .last  (tmr_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         addr_q <= '0;
         data_q <= '0;
         quad_q <= 1'b0;
         alt_q  <= 1'b0;
         idx    <= '0;
         code_q <= RC_OK;
         tmo_q  <= 1'b0;
      end else begin
         unique case (st)
            S_IDLE: if (req_valid) begin
               addr_q <= req_addr;
               data_q <= req_data;
               quad_q <= req_quad;
               alt_q  <= req_alt;
               code_q <= RC_OK;
               tmo_q  <= 1'b0;
               st     <= S_CMD;
            end
            S_CMD: if (fire) begin
               idx <= '0;
               st  <= S_DATA;
            end
            S_DATA: if (fire) begin
               if (last_byte) st <= S_POLL;
               else           idx <= idx + 1'b1;
            end
            S_POLL: if (fire) begin
               if (dev_ready) begin
                  code_q <= code_w;
                  st     <= (code_w != RC_OK) ? S_CLEAR : S_RESP;
               end else if (susp_pend) begin
                  st <= S_SUSP;
               end else if (tmr_last) begin
                  tmo_q <= 1'b1;
                  st    <= S_RESP;
               end
            end
            S_SUSP:   if (fire) st <= S_PARK;
            S_PARK:   if (resume_req) st <= S_RESUME;
            S_RESUME: if (fire) st <= S_POLL;
            S_CLEAR:  if (fire) st <= S_RESP;
            S_RESP:   if (rsp_ready) st <= S_IDLE;
            default:  st <= S_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         susp_pend <= 1'b0;
      else if (st == S_IDLE)
         susp_pend <= 1'b0;
      else if (st == S_POLL && fire && !dev_ready && susp_pend)
         susp_pend <= 1'b0;
      else if (suspend_req && (st == S_CMD || st == S_DATA || st == S_POLL))
         susp_pend <= 1'b1;
   end

   always_comb begin
      bus_req   = 1'b0;
      bus_we    = 1'b1;
      bus_wdata = '0;
      unique case (st)
         S_CMD:    begin bus_req = 1'b1; bus_wdata = alt_q ? OP_PROG_ALT : OP_PROG; end
         S_DATA:   begin bus_req = 1'b1; bus_wdata = lane[idx]; end
         S_POLL:   begin bus_req = 1'b1; bus_we = 1'b0; end
         S_SUSP:   begin bus_req = 1'b1; bus_wdata = OP_SUSP; end
         S_RESUME: begin bus_req = 1'b1; bus_wdata = OP_RESUME; end
         S_CLEAR:  begin bus_req = 1'b1; bus_wdata = OP_CLEAR; end
         default:  ;
      endcase
   end

   assign bus_addr    = addr_q;
   assign req_ready   = (st == S_IDLE);
   assign rsp_valid   = (st == S_RESP);
   assign rsp_code    = code_q;
   assign rsp_timeout = tmo_q;
   assign suspended   = (st == S_PARK);

   // Tracks whether a clear-status write completed in the current operation.
   logic clr_seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   clr_seen <= 1'b0;
      else if (st == S_IDLE)        clr_seen <= 1'b0;
      else if (fire && bus_we && bus_wdata == OP_CLEAR && st == S_CLEAR) clr_seen <= 1'b1;
   end

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!rsp_valid && !bus_req && !suspended));
   p_busy_refuse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && req_valid) |=> !req_ready);
   p_bus_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)));
   p_clear_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_code != 2'd0) |-> clr_seen);
   p_no_clear_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_code == 2'd0) |-> !clr_seen);
   p_park_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      suspended |-> !bus_req);
   p_tmo_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_timeout) |-> (rsp_code == 2'd0));
   p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_code) && $stable(rsp_timeout)));
endmodule

// File: tb/fps_seq_tb_top.sv
module fps_seq_tb_top;
   localparam int AW = 24;
   localparam int MP = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_quad = 1'b0, req_alt = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [31:0]   req_data = '0;
   logic          rsp_ready = 1'b1, suspend_req = 1'b0, resume_req = 1'b0;
   logic          req_ready, rsp_valid, rsp_timeout, suspended;
   logic [1:0]    rsp_code;
   logic          bus_req, bus_we, bus_ack = 1'b0;
   logic [AW-1:0] bus_addr;
   logic [7:0]    bus_wdata, bus_rdata = '0;

   always #2.5 clk = ~clk;

   fps_seq #(.ADDR_W(AW), .MAX_POLLS(MP)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_data(req_data), .req_quad(req_quad), .req_alt(req_alt),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_code(rsp_code),
      .rsp_timeout(rsp_timeout), .suspend_req(suspend_req), .resume_req(resume_req),
      .suspended(suspended), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
   );

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   // scoreboard queues
   logic [AW+8:0] exp_bus [$];
   string         exp_bus_tag [$];
   logic [2:0]    exp_rsp [$];
   string         exp_rsp_tag [$];

   // device model settings
   int         busy_n = 0;
   int         rd_cnt = 0;
   logic [7:0] busy_stat = 8'h18;
   logic [7:0] done_stat = 8'h80;

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic exp_wr(input logic [AW-1:0] a, input logic [7:0] d, input string tag);
      exp_bus.push_back({1'b1, a, d});
      exp_bus_tag.push_back(tag);
   endtask

   task automatic exp_rd(input logic [AW-1:0] a, input int n);
      for (int i = 0; i < n; i++) begin
         exp_bus.push_back({1'b0, a, 8'h00});
         exp_bus_tag.push_back("R4 status read");
      end
   endtask

   task automatic exp_resp(input logic [1:0] c, input logic t, input string tag);
      exp_rsp.push_back({t, c});
      exp_rsp_tag.push_back(tag);
   endtask

   // monitor and bus target, all at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         if (rsp_valid && rsp_ready) begin
            if (exp_rsp.size() == 0) begin
               check(0, "R7 unexpected response", {rsp_timeout, rsp_code}, 0);
            end else begin
               logic [2:0] e;
               string tg;
               e = exp_rsp.pop_front();
               tg = exp_rsp_tag.pop_front();
               check({rsp_timeout, rsp_code} == e, tg, {rsp_timeout, rsp_code}, e);
            end
         end
         if (bus_req && !bus_ack) begin
            if (exp_bus.size() == 0) begin
               check(0, "R7 unexpected bus cycle", {bus_we, bus_addr, bus_wdata}, 0);
            end else begin
               logic [AW+8:0] e;
               string tg;
               e = exp_bus.pop_front();
               tg = exp_bus_tag.pop_front();
               if (e[AW+8])
                  check({bus_we, bus_addr, bus_wdata} == e, tg, {bus_we, bus_addr, bus_wdata}, e);
               else
                  check({bus_we, bus_addr} == e[AW+8:8], tg, {bus_we, bus_addr}, e[AW+8:8]);
            end
            if (!bus_we) begin
               bus_rdata = (rd_cnt < busy_n) ? busy_stat : done_stat;
               rd_cnt++;
            end
            bus_ack = 1'b1;
         end else begin
            bus_ack = 1'b0;
         end
      end
   end

   task automatic setup_dev(input int nbusy, input logic [7:0] done);
      busy_n = nbusy;
      rd_cnt = 0;
      done_stat = done;
   endtask

   task automatic issue(input logic [AW-1:0] a, input logic [31:0] d, input logic q, input logic alt);
      @(posedge clk); #1;
      req_addr = a; req_data = d; req_quad = q; req_alt = alt; req_valid = 1'b1;
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   task automatic wait_idle();
      while (!(req_ready && exp_rsp.size() == 0 && exp_bus.size() == 0)) @(posedge clk);
      repeat (3) @(posedge clk);
   endtask

   task automatic push_prog(input logic [AW-1:0] a, input logic [31:0] d, input logic q, input logic alt);
      exp_wr(a, alt ? 8'h10 : 8'h40, "R2 program opcode");
      exp_wr(a, d[7:0], "R3 byte 0");
      exp_wr(a, d[15:8], "R3 byte 1");
      if (q) begin
         exp_wr(a, d[23:16], "R3 byte 2");
         exp_wr(a, d[31:24], "R3 byte 3");
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check(req_ready == 1'b1, "R1 req_ready after reset", req_ready, 1);
      check({rsp_valid, bus_req, suspended} == 3'b000, "R1 outputs idle after reset",
            {rsp_valid, bus_req, suspended}, 0);
      rst_n = 1'b1;

      // success, double mode, odd address, busy reads with error bits ignored (R4, R5)
      setup_dev(2, 8'hA5);
      push_prog(24'h012343, 32'h0000_BEEF, 1'b0, 1'b0);
      exp_rd(24'h012343, 3);
      exp_resp(2'd0, 1'b0, "R5 ready with unranked bits gives ok");
      issue(24'h012343, 32'h0000_BEEF, 1'b0, 1'b0);
      wait_idle();

      // quad mode, alt opcode, all error bits: voltage wins; intruding request (R7)
      setup_dev(1, 8'h9A);
      push_prog(24'h00ABCE, 32'h4433_2211, 1'b1, 1'b1);
      exp_rd(24'h00ABCE, 2);
      exp_wr(24'h00ABCE, 8'h50, "R6 clear after voltage error");
      exp_resp(2'd1, 1'b0, "R5 voltage error code");
      issue(24'h00ABCE, 32'h4433_2211, 1'b1, 1'b1);
      #1;
      req_addr = 24'h777777; req_data = 32'hDEAD_0000; req_valid = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b0, "R7 req_ready low while busy", req_ready, 0);
      repeat (3) @(posedge clk);
      #1 req_valid = 1'b0;
      wait_idle();

      // program error beats protection; response held (R10)
      setup_dev(0, 8'h92);
      push_prog(24'h000100, 32'h0000_1234, 1'b0, 1'b0);
      exp_rd(24'h000100, 1);
      exp_wr(24'h000100, 8'h50, "R6 clear after program error");
      exp_resp(2'd2, 1'b0, "R5 program error code");
      rsp_ready = 1'b0;
      issue(24'h000100, 32'h0000_1234, 1'b0, 1'b0);
      while (!rsp_valid) @(negedge clk);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check(rsp_valid && rsp_code == 2'd2, "R10 response held", {rsp_valid, rsp_code}, 3'b110);
      end
      @(posedge clk); #1 rsp_ready = 1'b1;
      wait_idle();

      // protection error only
      setup_dev(1, 8'h82);
      push_prog(24'h3FFFFF, 32'hCAFE_F00D, 1'b1, 1'b0);
      exp_rd(24'h3FFFFF, 2);
      exp_wr(24'h3FFFFF, 8'h50, "R6 clear after protection error");
      exp_resp(2'd3, 1'b0, "R5 protection error code");
      issue(24'h3FFFFF, 32'hCAFE_F00D, 1'b1, 1'b0);
      wait_idle();

      // suspend and resume (R8)
      setup_dev(5, 8'h80);
      push_prog(24'h004441, 32'h0000_5A5A, 1'b0, 1'b0);
      exp_rd(24'h004441, 1);
      exp_wr(24'h004441, 8'hB0, "R8 suspend opcode");
      exp_wr(24'h004441, 8'hD0, "R8 resume opcode");
      exp_rd(24'h004441, 5);
      exp_resp(2'd0, 1'b0, "R8 completes after resume");
      issue(24'h004441, 32'h0000_5A5A, 1'b0, 1'b0);
      suspend_req = 1'b1;
      @(posedge clk); #1 suspend_req = 1'b0;
      while (!suspended) @(posedge clk);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check(suspended && !bus_req, "R8 parked without bus cycles", {suspended, bus_req}, 2'b10);
      end
      @(posedge clk); #1 resume_req = 1'b1;
      @(posedge clk); #1 resume_req = 1'b0;
      wait_idle();

      // poll limit (R9)
      setup_dev(100, 8'h80);
      push_prog(24'h000002, 32'h0000_0102, 1'b0, 1'b0);
      exp_rd(24'h000002, MP);
      exp_resp(2'd0, 1'b1, "R9 timeout result");
      issue(24'h000002, 32'h0000_0102, 1'b0, 1'b0);
      wait_idle();

      check(exp_bus.size() == 0 && exp_rsp.size() == 0, "R7 no leftover expectations",
            exp_bus.size() + exp_rsp.size(), 0);
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule